// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns one indexed-mode post byte into a 16-bit effective address. Along with the post byte, the caller supplies the offset extension bytes and the current values of the index registers, the stack pointer, the next-instruction address and the two byte accumulators. The post byte selects one of several forms:
- a short constant offset,
- a 9-bit or 16-bit constant offset,
- an accumulator offset,
- a pre- or post- auto increment or decrement of the base register,
- an indirect form, which fetches a two-byte pointer through a byte-wide read port and returns that pointer as the address.

Requests arrive on a valid/ready stream. `req_ready` is high only while the block is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. All request fields and register inputs must be valid in that cycle, and the caller holds them until they are taken. The block accepts nothing more until it has produced a one-cycle `done` pulse. During that pulse, the address, the illegal flag and the register write-back are valid. Memory reads use a request/valid handshake. The block holds `mem_req` and `mem_addr` until the cycle in which `mem_valid` is seen, and `mem_data` is taken in that same cycle.

A load-effective-address request sends the computed address to a chosen destination register in place of the usual base write-back. All arithmetic wraps modulo 2^16.

Top module: `idx_ea_gen`

## Requirements
- R1: A post byte with bit 5 clear uses the base register selected by bits 7:6 (00 X, 01 Y, 10 SP, 11 PC). The address is that base plus the sign-extended 5-bit field in bits 4:0. No write-back is made.
- R2: The post byte 111rr0zs has a constant offset. When z=0, the offset is 9 bits: s is the sign and `req_ext[7:0]` is the low byte. When z=1 and s=0, the offset is the 16-bit `req_ext`. No write-back is made.
- R3: The post byte 111rr1aa with aa=00, 01 or 10 adds an accumulator to the base. 00 adds A zero-extended, 01 adds B zero-extended, and 10 adds D = {A,B}.
- R4: The post byte rr1pnnnn, where bits 7:5 are not 111, is an auto-modify form on base rr. The field nnnn read as a signed 4-bit number n gives a step of n+1 when n≥0 and n when n<0. With p=0 (pre), the address is the updated base. With p=1 (post), the address is the old base. The write-back drives `wb_en`=1, `wb_sel`=rr and `wb_val`=base+step.
- R5: For post bytes starting with 111, the base register comes from bits 4:3 (00 X, 01 Y, 10 SP, 11 PC). Whenever PC is the base, the `pc_next` input is used.
- R6: The post bytes 111rr011 (base + `req_ext`) and 111rr111 (base + D) are indirect. The block reads the byte at the pointer location as the high byte and the byte at location+1 (wrapping) as the low byte. The address is {high, low}.
- R7: An indirect request makes exactly two reads and every other request makes none. `mem_addr` stays stable while `mem_req` waits for `mem_valid`.
- R8: When a load-effective-address request (`req_lea`=1) carries a non-indirect post byte and `req_dst` is 00 X, 01 Y or 10 SP, the output is `wb_en`=1, `wb_sel`=`req_dst` and `wb_val`=the address. The base register is not written back.
- R9: When a load-effective-address request carries an indirect post byte or `req_dst`=11, `illegal` is raised, `wb_en`=0 and no memory read is made.
- R10: `done` is a one-cycle pulse. `req_ready` is low from acceptance until after that pulse.
- R11: After reset, `req_ready`=1, `done`=0 and `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_xb | input | 8 | Post byte |
| req_ext | input | 16 | Offset extension bytes |
| req_lea | input | 1 | Load-effective-address request |
| req_dst | input | 2 | Destination register for load-effective-address |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| pc_next | input | 16 | Next instruction address, used as the PC base |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 8 | Read data |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| illegal | output | 1 | Request was illegal |
| wb_en | output | 1 | Register write-back valid |
| wb_sel | output | 2 | Write-back register (00 X, 01 Y, 10 SP) |
| wb_val | output | 16 | Write-back value |

## Verification
Each transaction leaves its mark on the ports at its own `done` pulse.

- A decode or arithmetic slip shows up as a wrong `ea` or `wb_val` on that pulse.
- A sequencer that loses its place shows up in different ways:
  - an extra or missing read is caught in the per-request read count;
  - a swapped byte order shows up in the indirect address;
  - a stuck state shows up as a pulse that never comes.

Random post bytes cover every encoding, and random read latencies stress the handshake. Directed cases pin the worked pointer examples, the offset wrap, the pointer wrap at FFFF, the PC base and the illegal load-effective-address cases.

// File: rtl/ieag_pkg.sv
package ieag_pkg;
  localparam int AW = 16;
  localparam int BW = AW / 2;

  typedef enum logic [1:0] {K_CONST, K_ACC, K_AUTO, K_IND} kind_e;

  typedef struct packed {
    kind_e          kind;
    logic [1:0]     base;
    logic           use_acc;
    logic [1:0]     acc_sel;
    logic           pre;
    logic [3:0]     step;
    logic [AW-1:0]  offs;
  } xdec_t;
endpackage

// File: rtl/ieag_decode.sv
module ieag_decode
  import ieag_pkg::*;
(
  input  logic [7:0]    xb,
  input  logic [AW-1:0] ext,
  output xdec_t         dec
);
  always_comb begin
    dec      = '0;
    dec.kind = K_CONST;
    if (!xb[5]) begin
      dec.base = xb[7:6];
      dec.offs = {{(AW-5){xb[4]}}, xb[4:0]};
    end else if (xb[7:5] != 3'b111) begin
      dec.kind = K_AUTO;
      dec.base = xb[7:6];
      dec.pre  = !xb[4];
      dec.step = xb[3:0];
    end else begin
      dec.base = xb[4:3];
      if (!xb[2]) begin
        if (!xb[1]) begin
          dec.offs = {{(AW-BW){xb[0]}}, ext[BW-1:0]};
        end else begin
          dec.offs = ext;
          if (xb[0]) dec.kind = K_IND;
        end
      end else begin
        dec.use_acc = 1'b1;
        dec.acc_sel = xb[1:0];
        dec.kind    = (xb[1:0] == 2'b11) ? K_IND : K_ACC;
      end
    end
  end
endmodule

// File: rtl/ieag_calc.sv
module ieag_calc
  import ieag_pkg::*;
(
  input  xdec_t         dec,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_sp,
  input  logic [AW-1:0] pc_next,
  input  logic [BW-1:0] acc_a,
  input  logic [BW-1:0] acc_b,
  output logic [AW-1:0] addr,
  output logic          wb_req,
  output logic [AW-1:0] wb_val
);
  logic [AW-1:0] bv, av, delta, moved;

  always_comb begin
    case (dec.base)
      2'b00:   bv = reg_x;
      2'b01:   bv = reg_y;
      2'b10:   bv = reg_sp;
      default: bv = pc_next;
    endcase
    case (dec.acc_sel)
      2'b00:   av = {{(AW-BW){1'b0}}, acc_a};
      2'b01:   av = {{(AW-BW){1'b0}}, acc_b};
      default: av = {acc_a, acc_b};
    endcase
    delta = dec.step[3] ? {{(AW-4){1'b1}}, dec.step}
                        : {{(AW-4){1'b0}}, dec.step} + 1'b1;
    moved = bv + delta;
    if (dec.kind == K_AUTO) begin
      addr   = dec.pre ? moved : bv;
      wb_req = 1'b1;
    end else begin
      addr   = bv + (dec.use_acc ? av : dec.offs);
      wb_req = 1'b0;
    end
    wb_val = moved;
  end

  // R4
  always_comb begin
    auto_base_chk: assert (dec.kind != K_AUTO || dec.base != 2'b11);
  end
endmodule

// File: rtl/ieag_seq.sv
module ieag_seq
  import ieag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          lea,
  input  logic [1:0]    dst,
  input  kind_e         kind,
  input  logic [1:0]    base,
  input  logic [AW-1:0] addr,
  input  logic          wb_req,
  input  logic [AW-1:0] wb_val_in,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [BW-1:0] mem_data,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          illegal,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val
);
  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO, S_DONE} st_e;
  st_e st;
  logic [AW-1:0] ea_q, ptr_q, wbv_q;
  logic [BW-1:0] hi_q;
  logic          lea_q, ill_q, wbr_q;
  logic [1:0]    dst_q, base_q;
  logic          take, bad;

  assign req_ready = (st == S_IDLE);
  assign take      = req_valid && req_ready;
  assign bad       = lea && (kind == K_IND || dst == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ea_q <= '0; ptr_q <= '0; wbv_q <= '0; hi_q <= '0;
      lea_q <= 1'b0; ill_q <= 1'b0; wbr_q <= 1'b0;
      dst_q <= '0; base_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          ea_q   <= addr;
          ptr_q  <= addr;
          wbv_q  <= wb_val_in;
          wbr_q  <= wb_req;
          lea_q  <= lea;
          ill_q  <= bad;
          dst_q  <= dst;
          base_q <= base;
          st     <= (kind == K_IND && !bad) ? S_HI : S_DONE;
        end
        S_HI: if (mem_valid) begin
          hi_q <= mem_data;
          st   <= S_LO;
        end
        S_LO: if (mem_valid) begin
          ea_q <= {hi_q, mem_data};
          st   <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req  = (st == S_HI) || (st == S_LO);
  assign mem_addr = (st == S_LO) ? ptr_q + 1'b1 : ptr_q;
  assign done     = (st == S_DONE);
  assign ea       = ea_q;
  assign illegal  = done && ill_q;
  assign wb_en    = done && !ill_q && (lea_q || wbr_q);
  assign wb_sel   = lea_q ? dst_q : base_q;
  assign wb_val   = lea_q ? ea_q : wbv_q;

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
  // R6
  second_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI && mem_valid) |=> (mem_req && mem_addr == $past(mem_addr) + 1'b1));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  // R9
  illegal_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wb_en && !mem_req));
  // R8
  wb_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_sel != 2'b11));
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import ieag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [7:0]    req_xb,
  input  logic [15:0]   req_ext,
  input  logic          req_lea,
  input  logic [1:0]    req_dst,
  input  logic [15:0]   reg_x,
  input  logic [15:0]   reg_y,
  input  logic [15:0]   reg_sp,
  input  logic [15:0]   pc_next,
  input  logic [7:0]    acc_a,
  input  logic [7:0]    acc_b,
  output logic          mem_req,
  output logic [15:0]   mem_addr,
  input  logic          mem_valid,
  input  logic [7:0]    mem_data,
  output logic          done,
  output logic [15:0]   ea,
  output logic          illegal,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [15:0]   wb_val
);
  xdec_t         dec;
  logic [AW-1:0] c_addr, c_wbv;
  logic          c_wbr;

  ieag_decode u_dec (.xb(req_xb), .ext(req_ext), .dec(dec));

  ieag_calc u_calc (
    .dec(dec), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp),
    .pc_next(pc_next), .acc_a(acc_a), .acc_b(acc_b),
    .addr(c_addr), .wb_req(c_wbr), .wb_val(c_wbv)
  );

  ieag_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .lea(req_lea), .dst(req_dst), .kind(dec.kind), .base(dec.base),
    .addr(c_addr), .wb_req(c_wbr), .wb_val_in(c_wbv),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_data(mem_data), .done(done), .ea(ea), .illegal(illegal),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
  );
endmodule

// File: tb/sim_idx_ea_gen.sv
`timescale 1ns/1ps
module sim_idx_ea_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_lea = 1'b0;
  logic [7:0] req_xb = '0, acc_a = '0, acc_b = '0, mem_data = '0;
  logic [15:0] req_ext = '0, reg_x = '0, reg_y = '0, reg_sp = '0, pc_next = '0;
  logic [1:0] req_dst = '0;
  logic mem_valid = 1'b0;
  logic req_ready, mem_req, done, illegal, wb_en;
  logic [15:0] mem_addr, ea, wb_val;
  logic [1:0] wb_sel;
  int checks = 0, errors = 0, cyc = 0, reads = 0, wait_c = 0;

  always #2.5 clk = ~clk;

  idx_ea_gen u0 (.*);

  function automatic logic [7:0] memb(input logic [15:0] a);
    case (a)
      16'h0843: memb = 8'h08;
      16'h0844: memb = 8'h67;
      16'h0855: memb = 8'h08;
      16'h0856: memb = 8'h23;
      default:  memb = (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_valid = 1'b0; wait_c = 0;
    end else if (mem_valid) mem_valid = 1'b0;
    else if (mem_req) begin
      if (wait_c == 0) begin
        mem_valid = 1'b1; mem_data = memb(mem_addr);
        reads++; wait_c = $urandom % 3;
      end else wait_c--;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] basev(input logic [1:0] r);
    case (r)
      2'b00: basev = reg_x;
      2'b01: basev = reg_y;
      2'b10: basev = reg_sp;
      default: basev = pc_next;
    endcase
  endfunction

  function automatic string tagof(input logic [7:0] xb, input bit lea, input logic [1:0] d);
    bit ind = (xb[7:5] == 3'b111) && (xb[1:0] == 2'b11);
    if (lea) tagof = (ind || d == 2'b11) ? "R9" : "R8";
    else if (!xb[5]) tagof = "R1";
    else if (xb[7:5] != 3'b111) tagof = "R4";
    else if (ind) tagof = "R6";
    else if (!xb[2]) tagof = "R2";
    else tagof = "R3";
  endfunction

  // reference model per requirements
  task automatic model(output logic [15:0] e, output bit we, output logic [1:0] ws,
                       output logic [15:0] wv, output bit il, output int nr);
    logic [15:0] b, p, st;
    logic [3:0] n;
    bit ind = 0;
    we = 0; ws = 0; wv = 0; nr = 0;
    if (!req_xb[5]) begin
      e = basev(req_xb[7:6]) + {{11{req_xb[4]}}, req_xb[4:0]};
    end else if (req_xb[7:5] != 3'b111) begin
      b = basev(req_xb[7:6]); n = req_xb[3:0];
      st = n[3] ? {12'hFFF, n} : {12'h000, n} + 16'd1;
      e = req_xb[4] ? b : b + st;
      we = 1; ws = req_xb[7:6]; wv = b + st;
    end else begin
      b = basev(req_xb[4:3]);
      case (req_xb[2:0])
        3'b000: e = b + {8'h00, req_ext[7:0]};
        3'b001: e = b + {8'hFF, req_ext[7:0]};
        3'b010: e = b + req_ext;
        3'b011: begin ind = 1; p = b + req_ext; end
        3'b100: e = b + {8'h00, acc_a};
        3'b101: e = b + {8'h00, acc_b};
        3'b110: e = b + {acc_a, acc_b};
        default: begin ind = 1; p = b + {acc_a, acc_b}; end
      endcase
      if (ind) e = {memb(p), memb(p + 16'd1)};
    end
    il = req_lea && (ind || req_dst == 2'b11);
    if (il) begin we = 0; end
    else begin
      if (ind) nr = 2;
      if (req_lea) begin we = 1; ws = req_dst; wv = e; end
    end
  endtask

  task automatic run(input logic [7:0] xb, input logic [15:0] ext, input bit lea,
                     input logic [1:0] d, input string note);
    logic [15:0] e, wv; bit we, il; logic [1:0] ws; int nr, r0;
    string t;
    @(negedge clk);
    req_xb = xb; req_ext = ext; req_lea = lea; req_dst = d;
    model(e, we, ws, wv, il, nr);
    t = tagof(xb, lea, d);
    r0 = reads;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(illegal == il, t, {note, " illegal"}, {15'b0, illegal}, {15'b0, il});
    if (!il) chk(ea == e, t, {note, " ea"}, ea, e);
    chk(wb_en == we, t, {note, " wb_en"}, {15'b0, wb_en}, {15'b0, we});
    if (we && wb_en) begin
      chk(wb_sel == ws, t, {note, " wb_sel"}, {14'b0, wb_sel}, {14'b0, ws});
      chk(wb_val == wv, t, {note, " wb_val"}, wb_val, wv);
    end
    chk((reads - r0) == nr, "R7", {note, " read count"}, 16'(reads - r0), 16'(nr));
    chk(!req_ready, "R10", {note, " ready low at done"}, {15'b0, req_ready}, 16'h0);
    @(negedge clk);
    chk(!done && req_ready, "R10", {note, " done one cycle"}, {15'b0, done}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready && !done && !mem_req, "R11", "reset outputs",
        {13'b0, req_ready, done, mem_req}, 16'h4);
    rst_n = 1'b1;
    @(negedge clk);
    void'($urandom(32'd12345));

    // R6 worked pointer examples
    reg_x = 16'h0843; acc_a = 0; acc_b = 0;
    run(8'hE7, 16'h0, 0, 0, "D-indirect example");
    chk(ea == 16'h0867, "R6", "D-indirect literal", ea, 16'h0867);
    run(8'hE3, 16'h0012, 0, 0, "offset-indirect example");
    chk(ea == 16'h0823, "R6", "offset-indirect literal", ea, 16'h0823);
    // R6 pointer wrap at FFFF
    reg_x = 16'hFFFF;
    run(8'hE3, 16'h0000, 0, 0, "pointer wrap");
    // R2 16-bit offset wrap, 9-bit negative
    run(8'hE2, 16'h0002, 0, 0, "offset wrap");
    reg_x = 16'h0100;
    run(8'hE1, 16'h00F0, 0, 0, "9-bit negative");
    // R5 PC base uses pc_next
    pc_next = 16'h4000;
    run(8'hFA, 16'h0010, 0, 0, "R5 pc base");
    chk(ea == 16'h4010, "R5", "pc base literal", ea, 16'h4010);
    // R8 transfer and subtract
    reg_y = 16'h1234; reg_x = 16'h0050;
    run(8'h40, 16'h0, 1, 2'b00, "lea transfer");
    chk(wb_val == 16'h1234, "R8", "transfer literal", wb_val, 16'h1234);
    run(8'h1D, 16'h0, 1, 2'b00, "lea minus 3");
    chk(wb_val == 16'h004D, "R8", "minus 3 literal", wb_val, 16'h004D);
    // R9 illegal forms
    run(8'hE3, 16'h0012, 1, 2'b01, "lea indirect");
    run(8'h05, 16'h0, 1, 2'b11, "lea bad dst");
    // R4 pre +8 on SP, post -1 on Y
    reg_sp = 16'hFFFC;
    run(8'hA7, 16'h0, 0, 0, "pre inc 8");
    run(8'h7F, 16'h0, 0, 0, "post dec 1");
    // R3 accumulators
    acc_a = 8'h80; acc_b = 8'hFF;
    run(8'hE4, 16'h0, 0, 0, "acc A");
    run(8'hED, 16'h0, 0, 0, "acc B");
    run(8'hF6, 16'h0, 0, 0, "acc D");

    for (int i = 0; i < 500; i++) begin
      reg_x = 16'($urandom); reg_y = 16'($urandom); reg_sp = 16'($urandom);
      pc_next = 16'($urandom); acc_a = 8'($urandom); acc_b = 8'($urandom);
      run(8'($urandom), 16'($urandom), ($urandom % 4) == 0, 2'($urandom), "random");
    end

    summary();
    $finish;
  end
endmodule